// File: doc/BRIEF.md
# Accumulator Machine Control Sequencer

This block sequences a small accumulator computer built around one shared data bus. Every transfer takes two clock cycles. A read strobe makes one unit drive the bus register at the end of a cycle. A write strobe makes another unit latch that register in a later cycle. Around the sequencer sit the instruction register, the accumulator, a B operand register, the program counter, a ripple-carry adder and an external combinational memory. The memory address is always the low bits of the bus register.

Every instruction begins with a three-cycle fetch. Its opcode then selects a fixed list of execute cycles: load-accumulator, add, jump or no-op. After the last execute cycle of every instruction except jump, the program counter increments and the next fetch starts.

The strobes come straight out of the block. A system model or a bench can see exactly which transfer happens in each clock.

Top module: `acc_seq_top`

## Requirements
- R1: A synchronous active-high reset clears the program counter, accumulator, carry and step counter. In the first cycle after reset the only strobe is the program counter read, which begins the fetch of address 0.
- R2: A fetch takes three cycles (steps 0..2). In step 0 the program counter drives the bus. In step 1 memory drives the bus. In step 2 the instruction register latches the bus.
- R3: In step 3, every instruction other than no-op reads the instruction register. The bus then takes the low ADDR_W bits of the instruction, zero-extended. The opcode is the two top bits of the instruction word.
- R4: Load (opcode 00) runs IR read, memory read, then accumulator write (steps 3..5). The accumulator ends up holding the memory word at the address field.
- R5: Add (opcode 01) runs IR read, memory read, B write, then ALU add together with accumulator write (steps 3..6). The accumulator becomes the old accumulator plus the memory word, modulo 2^DATA_W.
- R6: Jump (opcode 10) runs IR read, then program counter write (steps 3..4). The program counter takes the address field and is not incremented.
- R7: No-op (opcode 11) has one execute cycle (step 3) with no read or write strobe.
- R8: In the last execute cycle of a load, add or no-op, the pc_inc strobe is high and the program counter advances by one, wrapping modulo 2^ADDR_W.
- R9: At most one read strobe is high in any cycle. Every write strobe except the accumulator write in the ALU cycle follows a cycle that had a read strobe.
- R10: The memory address output equals the low ADDR_W bits of the bus register in every cycle.
- R11: The carry flag takes the adder's carry-out in the ALU cycle of an add and keeps its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_data_i | input | DATA_W | Combinational read data from memory at mem_addr_o |
| mem_addr_o | output | ADDR_W | Memory address, equal to the bus register's low bits |
| bus_o | output | DATA_W | Shared bus register |
| rd_strb_o | output | 3 | Read strobes: bit0 program counter, bit1 instruction register, bit2 memory |
| wr_strb_o | output | 4 | Write strobes: bit0 instruction register, bit1 accumulator, bit2 B, bit3 program counter |
| alu_add_o | output | 1 | ALU add selected; the result goes into the accumulator |
| pc_inc_o | output | 1 | Program counter increments at the end of this cycle |
| pc_o | output | ADDR_W | Program counter |
| acc_o | output | DATA_W | Accumulator |
| carry_o | output | 1 | Carry flag from the last add |
| step_o | output | 3 | Machine-cycle counter, 0 at the start of each fetch |

## Verification
A step counter that is wrong or stuck shows up at the strobe ports in the very cycle it goes wrong. The wrong strobe pattern appears at once, and step_o leaves the expected sequence. A corrupted instruction register or program counter shows up later. It appears within the next instruction, as a wrong opcode sequence, a wrong bus value in step 3, or a wrong memory address in the following fetch. Accumulator or carry faults reach the ports in the cycle right after the faulty write. Comparing every port in every cycle against a reference model therefore catches each such fault within a few cycles.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

    localparam int OP_W   = 2;
    localparam int STEP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_LDA = 2'b00,
        OP_ADD = 2'b01,
        OP_JMP = 2'b10,
        OP_NOP = 2'b11
    } opcode_e;

    localparam logic [STEP_W-1:0] ST_F_PC  = 3'd0;
    localparam logic [STEP_W-1:0] ST_F_MEM = 3'd1;
    localparam logic [STEP_W-1:0] ST_F_IR  = 3'd2;
    localparam logic [STEP_W-1:0] ST_E1    = 3'd3;
    localparam logic [STEP_W-1:0] ST_E2    = 3'd4;
    localparam logic [STEP_W-1:0] ST_E3    = 3'd5;
    localparam logic [STEP_W-1:0] ST_E4    = 3'd6;

    // bus drivers, bit0 = program counter
    typedef struct packed {
        logic mem;
        logic ir;
        logic pc;
    } rd_strb_t;

    // bus receivers, bit0 = instruction register
    typedef struct packed {
        logic pc;
        logic b;
        logic acc;
        logic ir;
    } wr_strb_t;

    typedef struct packed {
        rd_strb_t rd;
        wr_strb_t wr;
        logic     alu_add;
        logic     pc_inc;
    } ctrl_t;

    function automatic logic [STEP_W-1:0] final_step(opcode_e op);
        case (op)
            OP_LDA:  return ST_E3;
            OP_ADD:  return ST_E4;
            OP_JMP:  return ST_E2;
            default: return ST_E1;
        endcase
    endfunction

    function automatic ctrl_t step_controls(opcode_e op, logic [STEP_W-1:0] st);
        ctrl_t c;
        c = '0;
        case (st)
            ST_F_PC:  c.rd.pc  = 1'b1;
            ST_F_MEM: c.rd.mem = 1'b1;
            ST_F_IR:  c.wr.ir  = 1'b1;
            ST_E1: begin
                if (op == OP_NOP) c.pc_inc = 1'b1;
                else              c.rd.ir  = 1'b1;
            end
            ST_E2: begin
                if (op == OP_JMP)                       c.wr.pc  = 1'b1;
                else if (op == OP_LDA || op == OP_ADD)  c.rd.mem = 1'b1;
            end
            ST_E3: begin
                if (op == OP_LDA) begin
                    c.wr.acc = 1'b1;
                    c.pc_inc = 1'b1;
                end else if (op == OP_ADD) begin
                    c.wr.b = 1'b1;
                end
            end
            ST_E4: begin
                if (op == OP_ADD) begin
                    c.alu_add = 1'b1;
                    c.wr.acc  = 1'b1;
                    c.pc_inc  = 1'b1;
                end
            end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/acc_seq_ctrl.sv
module acc_seq_ctrl
    import acc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  opcode_e           op,
    output logic [STEP_W-1:0] step,
    output ctrl_t             ctrl
);

    logic [STEP_W-1:0] step_q;
    logic              at_end;

    assign at_end = (step_q == final_step(op));

    always_ff @(posedge clk) begin
        if (rst)         step_q <= '0;
        else if (at_end) step_q <= ST_F_PC;
        else             step_q <= step_q + 1'b1;
    end

    always_comb ctrl = step_controls(op, step_q);

    assign step = step_q;

endmodule

// File: rtl/acc_seq_alu.sv
module acc_seq_alu #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] sum,
    output logic              cout
);

    logic [DATA_W:0] c;

    assign c[0] = 1'b0;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign sum[i]  = a[i] ^ b[i] ^ c[i];
        assign c[i+1]  = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
    end

    assign cout = c[DATA_W];

endmodule

// File: rtl/acc_seq_dpath.sv
module acc_seq_dpath
    import acc_seq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl,
    input  logic [DATA_W-1:0] mem_data,
    output logic [DATA_W-1:0] bus_q,
    output logic [DATA_W-1:0] ir_q,
    output logic [DATA_W-1:0] acc_q,
    output logic [ADDR_W-1:0] pc_q,
    output logic              carry_q
);

    localparam int PAD_W = DATA_W - ADDR_W;

    logic [DATA_W-1:0] b_q;
    logic [DATA_W-1:0] sum;
    logic              cout;
    logic [DATA_W-1:0] bus_d;

    acc_seq_alu #(.DATA_W(DATA_W)) u_alu (
        .a    (acc_q),
        .b    (b_q),
        .sum  (sum),
        .cout (cout)
    );

    always_comb begin
        bus_d = bus_q;
        if (ctrl.rd.pc)       bus_d = {{PAD_W{1'b0}}, pc_q};
        else if (ctrl.rd.ir)  bus_d = {{PAD_W{1'b0}}, ir_q[ADDR_W-1:0]};
        else if (ctrl.rd.mem) bus_d = mem_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_q   <= '0;
            ir_q    <= '0;
            acc_q   <= '0;
            b_q     <= '0;
            pc_q    <= '0;
            carry_q <= 1'b0;
        end else begin
            bus_q <= bus_d;
            if (ctrl.wr.ir) ir_q <= bus_q;
            if (ctrl.wr.b)  b_q  <= bus_q;
            if (ctrl.alu_add) begin
                acc_q   <= sum;
                carry_q <= cout;
            end else if (ctrl.wr.acc) begin
                acc_q <= bus_q;
            end
            if (ctrl.wr.pc)       pc_q <= bus_q[ADDR_W-1:0];
            else if (ctrl.pc_inc) pc_q <= pc_q + 1'b1;
        end
    end

endmodule

// File: rtl/acc_seq_top.sv
module acc_seq_top
    import acc_seq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] mem_data_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] bus_o,
    output logic [2:0]        rd_strb_o,
    output logic [3:0]        wr_strb_o,
    output logic              alu_add_o,
    output logic              pc_inc_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic [DATA_W-1:0] acc_o,
    output logic              carry_o,
    output logic [2:0]        step_o
);

    ctrl_t             ctrl;
    opcode_e           op;
    logic [DATA_W-1:0] bus_q;
    logic [DATA_W-1:0] ir_q;
    logic [STEP_W-1:0] step;

    assign op = opcode_e'(ir_q[DATA_W-1 -: OP_W]);

    acc_seq_ctrl u_ctrl (
        .clk  (clk),
        .rst  (rst),
        .op   (op),
        .step (step),
        .ctrl (ctrl)
    );

    acc_seq_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dpath (
        .clk      (clk),
        .rst      (rst),
        .ctrl     (ctrl),
        .mem_data (mem_data_i),
        .bus_q    (bus_q),
        .ir_q     (ir_q),
        .acc_q    (acc_o),
        .pc_q     (pc_o),
        .carry_q  (carry_o)
    );

    assign mem_addr_o = bus_q[ADDR_W-1:0];
    assign bus_o      = bus_q;
    assign rd_strb_o  = ctrl.rd;
    assign wr_strb_o  = ctrl.wr;
    assign alu_add_o  = ctrl.alu_add;
    assign pc_inc_o   = ctrl.pc_inc;
    assign step_o     = step;

endmodule

// File: rtl/acc_seq_checks.sv
module acc_seq_checks #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic [2:0]        rd,
    input logic [3:0]        wr,
    input logic              alu_add,
    input logic              pc_inc,
    input logic [DATA_W-1:0] bus,
    input logic [ADDR_W-1:0] pc,
    input logic [DATA_W-1:0] acc,
    input logic              carry,
    input logic [2:0]        step
);

    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (step == 3'd0 && pc == '0 && acc == '0 && !carry));

    a_r2_pc_then_mem: assert property (@(posedge clk) disable iff (rst)
        rd[0] |=> rd[2]);

    a_r4_acc_from_bus: assert property (@(posedge clk) disable iff (rst)
        (wr[1] && !alu_add) |=> (acc == $past(bus)));

    a_r6_jump_target: assert property (@(posedge clk) disable iff (rst)
        wr[3] |=> (pc == $past(bus[ADDR_W-1:0])));

    a_r8_pc_advance: assert property (@(posedge clk) disable iff (rst)
        pc_inc |=> (pc == ADDR_W'($past(pc) + 1'b1)));

    a_r9_one_driver: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rd));

    a_r9_write_after_read: assert property (@(posedge clk) disable iff (rst)
        ((|wr) && !alu_add) |-> $past(|rd));

    a_r11_carry_hold: assert property (@(posedge clk) disable iff (rst)
        !alu_add |=> $stable(carry));

endmodule

bind acc_seq_top acc_seq_checks #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_checks (
    .clk     (clk),
    .rst     (rst),
    .rd      (rd_strb_o),
    .wr      (wr_strb_o),
    .alu_add (alu_add_o),
    .pc_inc  (pc_inc_o),
    .bus     (bus_o),
    .pc      (pc_o),
    .acc     (acc_o),
    .carry   (carry_o),
    .step    (step_o)
);

// File: tb/acc_seq_top_test.sv
`timescale 1ns/1ps
module acc_seq_top_test;

    localparam int DW = 8;
    localparam int AW = 6;
    localparam int MEM_N = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] mem_data;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] bus;
    logic [2:0]    rd;
    logic [3:0]    wr;
    logic          alu_add, pc_inc, carry;
    logic [AW-1:0] pc;
    logic [DW-1:0] acc;
    logic [2:0]    step;

    logic [DW-1:0] mem [MEM_N];

    int n_tests = 0;
    int n_fail  = 0;

    // reference state
    logic [DW-1:0] m_bus, m_ir, m_acc, m_b;
    logic [AW-1:0] m_pc;
    logic          m_carry;
    logic [2:0]    m_step;

    always #2.5 clk = ~clk;

    assign mem_data = mem[mem_addr];

    acc_seq_top #(.DATA_W(DW), .ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .mem_data_i(mem_data), .mem_addr_o(mem_addr),
        .bus_o(bus), .rd_strb_o(rd), .wr_strb_o(wr), .alu_add_o(alu_add),
        .pc_inc_o(pc_inc), .pc_o(pc), .acc_o(acc), .carry_o(carry), .step_o(step)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    // expected strobes per opcode/step, from the requirement text
    function automatic logic [2:0] exp_rd(logic [1:0] op, logic [2:0] st);
        if (st == 0) return 3'b001;
        if (st == 1) return 3'b100;
        if (st == 3 && op != 2'b11) return 3'b010;
        if (st == 4 && (op == 2'b00 || op == 2'b01)) return 3'b100;
        return 3'b000;
    endfunction

    function automatic logic [3:0] exp_wr(logic [1:0] op, logic [2:0] st);
        if (st == 2) return 4'b0001;
        if (st == 4 && op == 2'b10) return 4'b1000;
        if (st == 5 && op == 2'b00) return 4'b0010;
        if (st == 5 && op == 2'b01) return 4'b0100;
        if (st == 6 && op == 2'b01) return 4'b0010;
        return 4'b0000;
    endfunction

    function automatic logic [2:0] exp_last(logic [1:0] op);
        case (op)
            2'b00:   return 3'd5;
            2'b01:   return 3'd6;
            2'b10:   return 3'd4;
            default: return 3'd3;
        endcase
    endfunction

    function automatic string tag_of(logic [1:0] op, logic [2:0] st);
        if (st < 3) return "R2";
        if (op == 2'b11) return "R7";
        if (st == 3) return "R3";
        if (op == 2'b00) return "R4";
        if (op == 2'b01) return "R5";
        return "R6";
    endfunction

    task automatic model_reset();
        m_bus = '0; m_ir = '0; m_acc = '0; m_b = '0;
        m_pc = '0; m_carry = 1'b0; m_step = '0;
    endtask

    // assumes call at a negedge; returns at a negedge
    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            logic [1:0]    op;
            logic [2:0]    erd;
            logic [3:0]    ewr;
            logic          ealu, einc;
            logic [DW-1:0] nbus, nacc;
            logic [DW:0]   s;
            string         t;
            op   = m_ir[DW-1 -: 2];
            erd  = exp_rd(op, m_step);
            ewr  = exp_wr(op, m_step);
            ealu = (op == 2'b01 && m_step == 3'd6);
            einc = (op != 2'b10 && m_step == exp_last(op));
            t    = tag_of(op, m_step);
            chk(t,     "step",    step, m_step);
            chk(t,     "rd",      rd, erd);
            chk(t,     "wr",      wr, ewr);
            chk("R5",  "alu_add", alu_add, ealu);
            chk("R8",  "pc_inc",  pc_inc, einc);
            chk("R9",  "readers<=1", ($countones(rd) <= 1), 1);
            chk(t,     "bus",     bus, m_bus);
            chk("R10", "mem_addr", mem_addr, m_bus[AW-1:0]);
            chk("R8",  "pc",      pc, m_pc);
            chk(t,     "acc",     acc, m_acc);
            chk("R11", "carry",   carry, m_carry);
            // next state
            nbus = m_bus;
            if (erd[0])      nbus = {{(DW-AW){1'b0}}, m_pc};
            else if (erd[1]) nbus = {{(DW-AW){1'b0}}, m_ir[AW-1:0]};
            else if (erd[2]) nbus = mem[m_bus[AW-1:0]];
            s    = {1'b0, m_acc} + {1'b0, m_b};
            nacc = m_acc;
            if (ealu) begin nacc = s[DW-1:0]; m_carry = s[DW]; end
            else if (ewr[1]) nacc = m_bus;
            if (ewr[0]) m_ir = m_bus;
            if (ewr[2]) m_b  = m_bus;
            if (ewr[3]) m_pc = m_bus[AW-1:0];
            else if (einc) m_pc = m_pc + 1'b1;
            m_acc  = nacc;
            m_step = (m_step == exp_last(op)) ? 3'd0 : m_step + 1'b1;
            m_bus  = nbus;
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        // R1: cleared state, fetch of address 0 begins
        chk("R1", "step", step, 0);
        chk("R1", "pc", pc, 0);
        chk("R1", "acc", acc, 0);
        chk("R1", "carry", carry, 0);
        chk("R1", "rd", rd, 3'b001);
        chk("R1", "wr", wr, 0);
    endtask

    initial begin
        #(200000 * 5);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < MEM_N; i++) mem[i] = '0;
        // directed program
        mem[0]  = 8'h14;  // load 20
        mem[1]  = 8'h55;  // add 21
        mem[2]  = 8'h56;  // add 22
        mem[3]  = 8'hC0;  // no-op
        mem[4]  = 8'h88;  // jump 8
        mem[8]  = 8'h17;  // load 23
        mem[9]  = 8'h80;  // jump 0
        mem[20] = 8'h70;
        mem[21] = 8'h85;
        mem[22] = 8'h20;
        mem[23] = 8'hFF;
        model_reset();
        do_reset();

        run(6);
        chk("R4", "acc after load", acc, 8'h70);
        chk("R8", "pc after load", pc, 1);
        run(7);
        chk("R5", "acc after add", acc, 8'hF5);
        chk("R11", "carry clear", carry, 0);
        run(7);
        chk("R5", "acc wrapped", acc, 8'h15);
        chk("R11", "carry set", carry, 1);
        run(4);
        chk("R7", "pc after no-op", pc, 4);
        chk("R7", "acc kept", acc, 8'h15);
        run(5);
        chk("R6", "pc after jump", pc, 8);
        run(6);
        chk("R4", "acc load FF", acc, 8'hFF);
        chk("R11", "carry held", carry, 1);
        run(5);
        chk("R6", "jump to 0", pc, 0);
        run(40);

        // PC wrap at the top address
        for (int i = 0; i < MEM_N; i++) mem[i] = 8'hC0;
        mem[0] = 8'hBF;   // jump 63
        do_reset();
        run(5);
        chk("R6", "pc at top", pc, 63);
        run(4);
        chk("R8", "pc wrapped", pc, 0);

        // random programs with a fixed seed
        void'($urandom(32'd5150));
        for (int r = 0; r < 6; r++) begin
            for (int i = 0; i < MEM_N; i++) mem[i] = DW'($urandom);
            do_reset();
            run(300);
            do_reset();
            run(300);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule